// File: doc/BRIEF.md
# Berlekamp Error-Locator Solver

This block turns the syndromes of a binary BCH codeword into its error-locator polynomial sigma(x). A decoder pulses `start_i` with all 2T syndromes S1..S2T on `synd_i`. The block then runs the simplified iterative Berlekamp recurrence for binary codes, producing one new table row per clock cycle. Each row holds a candidate polynomial, a discrepancy and a doubled degree. Field products and quotients use log/antilog tables that are built in logic for the field GF(2^M) generated by `POLY`. Exponents are reduced modulo 2^M-1.

The run ends after T row steps, or earlier when enough discrepancies in a row are zero. The block then pulses `done_o` and holds the low T+1 coefficients of sigma(x) and its degree. A later root search reports how many roots it found on `root_cnt_i`. The block compares that count with the degree, and a mismatch means the sector cannot be corrected. The defaults are M=6, POLY=x^6+x+1 and T=4.

Top module: `bm_locator_solver`

## Requirements
- R1: While `rst_i` is high at a rising edge (synchronous, active high), the block clears its outputs: `done_o`, `sigma_o` and `deg_o` read zero from the next cycle.
- R2: `start_i` is sampled high at a rising edge while the block is idle. At that edge the block captures S_j (j=1..2T) from `synd_i[(j-1)*M +: M]`. The field element alpha is a root of `POLY`, and an element's bit i is the coefficient of alpha^i.
- R3: Consider errors at distinct bit positions p, with at most T of them, and S_j equal to the sum of alpha^(j*p) over those positions. For such syndromes `sigma_o` equals the product of (1 + alpha^p x), with coefficient k at `sigma_o[k*M +: M]` for k=0..T.
- R4: `deg_o` is half of the doubled degree of the final row. For the syndromes of R3 it equals the number of errors.
- R5: Rows are numbered by mu: -1, 0, then 2, 4, 6 and so on. A row with a nonzero discrepancy updates from the earlier row that has a nonzero discrepancy and the largest (2*mu - l)/2, where l is the doubled degree. On a tie the earliest such row wins. A zero discrepancy copies the row. The constant coefficient of the result is always 1.
- R6: Each zero discrepancy increments a counter. The run stops when the counter equals floor(v/2)+1+(v mod 2), where v = T-1-l/2 of the current row; when v < 0 the run does not stop early. The current row is then the result. With T=4, zero, one or no errors give `done_o` 3 cycles after the start edge.
- R7: Without an early stop, `done_o` rises T cycles after the start edge; with T=4 this holds for two or more errors. `done_o` is high for exactly one cycle, and `sigma_o` and `deg_o` hold until the next result.
- R8: A `start_i` that arrives while a run is in progress is ignored: neither the result nor its timing changes.
- R9: `match_o` is high exactly when `root_cnt_i` equals `deg_o`.
- R10: Every start re-initialises the whole row table, so the result of one run never depends on an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a solve with the syndromes on `synd_i` |
| synd_i | input | 2*T*M | S1..S2T, S_j at bits (j-1)*M upward |
| root_cnt_i | input | clog2(2T+1) | Root count from the later root search |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| sigma_o | output | (T+1)*M | Locator coefficients 0..T, coefficient k at bits k*M upward |
| deg_o | output | clog2(2T+1) | Degree of the locator |
| match_o | output | 1 | Root count equals degree |

## Verification
The bench feeds valid syndromes of error patterns from zero up to T errors. These include patterns that touch position 0 and position 2^M-2, whose products wrap around the exponent modulus. A wrong modulo reduction or a wrong pivot row would show up as a wrong locator coefficient. The zero-error and one-error cases must finish a cycle earlier than heavier patterns. A wrong exit threshold either runs to the full T steps or stops before the degree has grown, which gives a wrong latency or a wrong locator. A start pulse injected mid-run, a run with no errors directly after a full-weight run, and root counts off by one probe the input guard, the table re-initialisation and the degree check.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic {
        BM_IDLE = 1'b0,
        BM_RUN  = 1'b1
    } bm_state_e;

    // Doubled row index: -1 for the seed row, then 0, 2, 4, ...
    function automatic int row_mu(int j);
        return (j == 0) ? -1 : 2 * (j - 1);
    endfunction

    // Pivot merit of a row with doubled degree ldbl.
    function automatic int row_delta(int j, int ldbl);
        return (2 * row_mu(j) - ldbl) / 2;
    endfunction

    // Number of zero discrepancies after which the current row is final.
    // Zero means the run never stops early.
    function automatic int exit_limit(int t, int half_l);
        int v;
        v = t - half_l - 1;
        if (v < 0) return 0;
        return v / 2 + (((v % 2) != 0) ? 2 : 1);
    endfunction

endpackage

// File: rtl/bm_gf_tables.sv
module bm_gf_tables #(
    parameter int M    = 6,
    parameter int POLY = 'h43
) (
    output logic [M-1:0] alog_o [(1<<M)-1],
    output logic [M-1:0] log_o  [1<<M]
);
    localparam int NN = (1 << M) - 1;

    logic [M-1:0] walk;

    always_comb begin
        for (int e = 0; e < (1 << M); e++) log_o[e] = '0;
        walk = {{(M-1){1'b0}}, 1'b1};
        for (int i = 0; i < NN; i++) begin
            alog_o[i]   = walk;
            log_o[walk] = M'(i);
            walk = {walk[M-2:0], 1'b0} ^ (walk[M-1] ? POLY[M-1:0] : '0);
        end
    end

endmodule

// File: rtl/bm_pivot_pick.sv
module bm_pivot_pick import bm_pkg::*; #(
    parameter int T  = 4,
    parameter int LW = 5,
    parameter int RW = 3
) (
    input  logic [RW-1:0] step_i,
    input  logic          nz_i   [T+2],
    input  logic [LW-1:0] ldbl_i [T+2],
    output logic [RW-1:0] ro_o
);
    int best;

    always_comb begin
        best = -1;
        ro_o = '0;
        for (int j = 0; j < T + 2; j++) begin
            if (j < int'(step_i) && nz_i[j] &&
                row_delta(j, int'(ldbl_i[j])) > best) begin
                best = row_delta(j, int'(ldbl_i[j]));
                ro_o = RW'(j);
            end
        end
    end

endmodule

// File: rtl/bm_row_step.sv
module bm_row_step import bm_pkg::*; #(
    parameter int M  = 6,
    parameter int T  = 4,
    parameter int LW = 5,
    parameter int RW = 3
) (
    input  logic [M-1:0]  alog_i    [(1<<M)-1],
    input  logic [M-1:0]  log_i     [1<<M],
    input  logic [M-1:0]  syn_i     [2*T+1],
    input  logic [RW-1:0] step_i,
    input  logic [RW-1:0] ro_i,
    input  logic [M-1:0]  sig_cur_i [2*T+1],
    input  logic [M-1:0]  sig_piv_i [2*T+1],
    input  logic [M-1:0]  d_cur_i,
    input  logic [M-1:0]  d_piv_i,
    input  logic [LW-1:0] l_cur_i,
    input  logic [LW-1:0] l_piv_i,
    output logic [M-1:0]  sig_nx_o  [2*T+1],
    output logic [LW-1:0] l_nx_o,
    output logic [M-1:0]  d_nx_o
);
    localparam int NN   = (1 << M) - 1;
    localparam int W    = 2 * T + 1;
    localparam int HMAX = 2 * T;

    int diff, hc, hp, hn, src, ex, idx;

    always_comb begin
        diff = row_mu(int'(step_i)) - row_mu(int'(ro_i));
        hc   = int'(l_cur_i) / 2;
        hp   = int'(l_piv_i) / 2;
        hn   = hc;
        src  = 0;
        ex   = 0;
        if (d_cur_i == '0) begin
            sig_nx_o = sig_cur_i;
        end else begin
            hn = (hc > hp + diff) ? hc : hp + diff;
            if (hn > HMAX) hn = HMAX;
            for (int k = 0; k < W; k++) begin
                sig_nx_o[k] = sig_cur_i[k];
                src = k - diff;
                if (src >= 0 && src < W) begin
                    if (sig_piv_i[src] != '0) begin
                        ex = (int'(log_i[d_cur_i]) + NN - int'(log_i[d_piv_i])
                              + int'(log_i[sig_piv_i[src]])) % NN;
                        sig_nx_o[k] = sig_nx_o[k] ^ alog_i[ex];
                    end
                end
            end
        end
        l_nx_o = LW'(2 * hn);

        idx    = 2 * int'(step_i) + 1;
        d_nx_o = (idx <= 2 * T) ? syn_i[idx] : '0;
        for (int k = 1; k < W; k++) begin
            if (k <= hn && idx - k >= 1 && idx - k <= 2 * T) begin
                if (sig_nx_o[k] != '0 && syn_i[idx-k] != '0) begin
                    ex = (int'(log_i[sig_nx_o[k]]) + int'(log_i[syn_i[idx-k]])) % NN;
                    d_nx_o = d_nx_o ^ alog_i[ex];
                end
            end
        end
    end

endmodule

// File: rtl/bm_locator_solver.sv
module bm_locator_solver import bm_pkg::*; #(
    parameter int M    = 6,
    parameter int T    = 4,
    parameter int POLY = 'h43
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         start_i,
    input  logic [2*T*M-1:0]             synd_i,
    input  logic [$clog2(2*T+1)-1:0]     root_cnt_i,
    output logic                         done_o,
    output logic [(T+1)*M-1:0]           sigma_o,
    output logic [$clog2(2*T+1)-1:0]     deg_o,
    output logic                         match_o
);
    localparam int NN   = (1 << M) - 1;
    localparam int W    = 2 * T + 1;
    localparam int ROWS = T + 2;
    localparam int LW   = $clog2(4 * T + 1);
    localparam int RW   = $clog2(T + 2);
    localparam int DW   = $clog2(2 * T + 1);
    localparam int ZW   = $clog2(T + 1) + 1;

    bm_state_e     st_q;
    logic [RW-1:0] step_q;
    logic [ZW-1:0] zc_q, zc_nx;
    logic [M-1:0]  syn_q   [2*T];
    logic [M-1:0]  syn_ext [W];
    logic [M-1:0]  sig_q   [ROWS][W];
    logic [M-1:0]  dsc_q   [ROWS];
    logic [LW-1:0] lfd_q   [ROWS];
    logic          nz      [ROWS];

    logic [M-1:0]  alog [NN];
    logic [M-1:0]  glog [1<<M];
    logic [RW-1:0] ro;
    logic [M-1:0]  sig_cur [W];
    logic [M-1:0]  sig_piv [W];
    logic [M-1:0]  sig_nx  [W];
    logic [M-1:0]  fin_sig [W];
    logic [LW-1:0] l_nx, fin_l;
    logic [M-1:0]  d_nx;
    logic          early, last;

    // Syndrome view with a zero at index 0 so S_j sits at index j.
    assign syn_ext[0] = '0;
    for (genvar j = 1; j < W; j++) begin : g_syn
        assign syn_ext[j] = syn_q[j-1];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_nz
        assign nz[r] = (dsc_q[r] != '0);
    end

    always_comb begin
        for (int k = 0; k < W; k++) begin
            sig_cur[k] = sig_q[step_q][k];
            sig_piv[k] = sig_q[ro][k];
        end
    end

    bm_gf_tables #(.M(M), .POLY(POLY)) tables_i (
        .alog_o (alog),
        .log_o  (glog)
    );

    bm_pivot_pick #(.T(T), .LW(LW), .RW(RW)) pivot_i (
        .step_i (step_q),
        .nz_i   (nz),
        .ldbl_i (lfd_q),
        .ro_o   (ro)
    );

    bm_row_step #(.M(M), .T(T), .LW(LW), .RW(RW)) step_i (
        .alog_i    (alog),
        .log_i     (glog),
        .syn_i     (syn_ext),
        .step_i    (step_q),
        .ro_i      (ro),
        .sig_cur_i (sig_cur),
        .sig_piv_i (sig_piv),
        .d_cur_i   (dsc_q[step_q]),
        .d_piv_i   (dsc_q[ro]),
        .l_cur_i   (lfd_q[step_q]),
        .l_piv_i   (lfd_q[ro]),
        .sig_nx_o  (sig_nx),
        .l_nx_o    (l_nx),
        .d_nx_o    (d_nx)
    );

    always_comb begin
        zc_nx = zc_q + 1'b1;
        early = (dsc_q[step_q] == '0) &&
                (int'(zc_nx) == exit_limit(T, int'(lfd_q[step_q]) / 2));
        last  = (int'(step_q) == T);
        fin_l = early ? lfd_q[step_q] : l_nx;
        for (int k = 0; k < W; k++) fin_sig[k] = early ? sig_cur[k] : sig_nx[k];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= BM_IDLE;
            step_q  <= '0;
            zc_q    <= '0;
            done_o  <= 1'b0;
            sigma_o <= '0;
            deg_o   <= '0;
            for (int j = 0; j < 2 * T; j++) syn_q[j] <= '0;
            for (int r = 0; r < ROWS; r++) begin
                dsc_q[r] <= '0;
                lfd_q[r] <= '0;
                for (int k = 0; k < W; k++) sig_q[r][k] <= '0;
            end
        end else begin
            done_o <= 1'b0;
            case (st_q)
                BM_IDLE: begin
                    if (start_i) begin
                        for (int j = 0; j < 2 * T; j++) syn_q[j] <= synd_i[j*M +: M];
                        for (int r = 0; r < ROWS; r++) begin
                            dsc_q[r] <= '0;
                            lfd_q[r] <= '0;
                            for (int k = 0; k < W; k++) sig_q[r][k] <= '0;
                        end
                        sig_q[0][0] <= M'(1);
                        sig_q[1][0] <= M'(1);
                        dsc_q[0]    <= M'(1);
                        dsc_q[1]    <= synd_i[M-1:0];
                        step_q      <= RW'(1);
                        zc_q        <= '0;
                        st_q        <= BM_RUN;
                    end
                end
                BM_RUN: begin
                    if (dsc_q[step_q] == '0) zc_q <= zc_nx;
                    for (int k = 0; k < W; k++) sig_q[step_q + 1'b1][k] <= sig_nx[k];
                    lfd_q[step_q + 1'b1] <= l_nx;
                    if (early || last) begin
                        for (int k = 0; k <= T; k++) sigma_o[k*M +: M] <= fin_sig[k];
                        deg_o  <= DW'(fin_l >> 1);
                        done_o <= 1'b1;
                        st_q   <= BM_IDLE;
                    end else begin
                        dsc_q[step_q + 1'b1] <= d_nx;
                        step_q <= step_q + 1'b1;
                    end
                end
                default: st_q <= BM_IDLE;
            endcase
        end
    end

    assign match_o = (root_cnt_i == deg_o);

    // R7: the completion flag lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R5: constant coefficient of every result is one.
    a_r5_unit_constant: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (sigma_o[M-1:0] == M'(1)));

    // R5: an update row always pivots on an earlier row with nonzero discrepancy.
    a_r5_pivot_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BM_RUN && dsc_q[step_q] != '0) |-> (ro < step_q && dsc_q[ro] != '0));

    // R5: stored degrees are doubled, hence even.
    a_r5_even_degree: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BM_RUN) |-> (lfd_q[step_q][0] == 1'b0));

    // R7: a run stays within T row steps and advances one row per cycle.
    a_r7_step_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BM_RUN) |-> (step_q >= RW'(1) && int'(step_q) <= T));

    a_r8_step_advance: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == BM_RUN) |=> (st_q == BM_IDLE || step_q == $past(step_q) + 1'b1));

endmodule

// File: tb/bm_locator_solver_tb_top.sv
`timescale 1ns/1ps
module bm_locator_solver_tb_top;
    localparam int M    = 6;
    localparam int T    = 4;
    localparam int POLY = 'h43;
    localparam int NN   = (1 << M) - 1;
    localparam int SW   = 2 * T * M;
    localparam int OW   = (T + 1) * M;
    localparam int DW   = $clog2(2 * T + 1);
    localparam int NV   = 10;

    localparam int VW [NV]    = '{0, 1, 2, 3, 4, 4, 2, 3, 4, 1};
    localparam int VP [NV][4] = '{'{0, 0, 0, 0},   '{5, 0, 0, 0},
                                  '{0, 62, 0, 0},  '{1, 2, 3, 0},
                                  '{10, 20, 30, 40}, '{0, 1, 61, 62},
                                  '{7, 44, 0, 0},  '{13, 27, 58, 0},
                                  '{3, 9, 33, 50}, '{62, 0, 0, 0}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [SW-1:0] synd = '0;
    logic [DW-1:0] rcnt = '0;
    logic          done;
    logic [OW-1:0] sigma;
    logic [DW-1:0] deg;
    logic          match;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bm_locator_solver #(.M(M), .T(T), .POLY(POLY)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .start_i    (start),
        .synd_i     (synd),
        .root_cnt_i (rcnt),
        .done_o     (done),
        .sigma_o    (sigma),
        .deg_o      (deg),
        .match_o    (match)
    );

    function automatic logic [M-1:0] xt(logic [M-1:0] a);
        return {a[M-2:0], 1'b0} ^ (a[M-1] ? POLY[M-1:0] : '0);
    endfunction

    function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
        logic [M-1:0] r, aa;
        r = '0; aa = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) r = r ^ aa;
            aa = xt(aa);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] apow(int e);
        logic [M-1:0] r;
        r = M'(1);
        for (int i = 0; i < (e % NN); i++) r = xt(r);
        return r;
    endfunction

    function automatic logic [SW-1:0] mk_synd(int w, int p[4]);
        logic [SW-1:0] s;
        logic [M-1:0]  v;
        s = '0;
        for (int j = 1; j <= 2 * T; j++) begin
            v = '0;
            for (int e = 0; e < w; e++) v = v ^ apow((j * p[e]) % NN);
            s[(j-1)*M +: M] = v;
        end
        return s;
    endfunction

    function automatic logic [OW-1:0] mk_sigma(int w, int p[4]);
        logic [M-1:0]  c [T+1];
        logic [M-1:0]  x;
        logic [OW-1:0] o;
        for (int k = 0; k <= T; k++) c[k] = '0;
        c[0] = M'(1);
        for (int e = 0; e < w; e++) begin
            x = apow(p[e]);
            for (int k = T; k >= 1; k--) c[k] = c[k] ^ gmul(x, c[k-1]);
        end
        for (int k = 0; k <= T; k++) o[k*M +: M] = c[k];
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Pulse start for one edge and return the cycles until done_o.
    task automatic run_one(input logic [SW-1:0] s, output int lat);
        @(negedge clk); synd = s; start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (done) begin lat = c; break; end
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [SW-1:0] sa, sb;
        logic [OW-1:0] ex_sig, held;
        int lat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        chk(sigma == '0, "R1", "sigma after reset", longint'(sigma), 0);
        chk(deg == '0, "R1", "degree after reset", longint'(deg), 0);

        for (int v = 0; v < NV; v++) begin
            sa     = mk_synd(VW[v], VP[v]);
            ex_sig = mk_sigma(VW[v], VP[v]);
            run_one(sa, lat);
            chk(sigma == ex_sig, "R2 R3 R5", $sformatf("locator vec%0d", v),
                longint'(sigma), longint'(ex_sig));
            chk(int'(deg) == VW[v], "R4", $sformatf("degree vec%0d", v),
                longint'(deg), longint'(VW[v]));
            if (VW[v] <= 1)
                chk(lat == 3, "R6", $sformatf("early stop latency vec%0d", v), lat, 3);
            else
                chk(lat == T, "R7", $sformatf("full latency vec%0d", v), lat, T);
            rcnt = DW'(VW[v]);
            #1;
            chk(match == 1'b1, "R9", "root count equal", longint'(match), 1);
            rcnt = DW'(VW[v] + 1);
            #1;
            chk(match == 1'b0, "R9", "root count differs", longint'(match), 0);
            held = sigma;
            @(negedge clk);
            chk(done == 1'b0, "R7", "done pulse width", longint'(done), 0);
            chk(sigma == held, "R7", "result held", longint'(sigma), longint'(held));
        end

        // R8: a second start during a run leaves the first run untouched.
        sa     = mk_synd(VW[4], VP[4]);
        sb     = mk_synd(VW[1], VP[1]);
        ex_sig = mk_sigma(VW[4], VP[4]);
        @(negedge clk); synd = sa; start = 1'b1;
        @(negedge clk); synd = sb; start = 1'b1;
        lat = 0;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (done) begin lat = c; break; end
        end
        chk(sigma == ex_sig, "R8", "locator with mid-run start", longint'(sigma), longint'(ex_sig));
        chk(lat == T, "R8", "latency with mid-run start", lat, T);
        @(negedge clk);
        chk(done == 1'b0, "R8", "no extra result", longint'(done), 0);

        // R10: a clean run right after a full-weight one.
        run_one('0, lat);
        chk(sigma == OW'(1), "R10", "zero syndromes after full run", longint'(sigma), 1);
        chk(deg == '0, "R10", "zero degree after full run", longint'(deg), 0);
        chk(lat == 3, "R6", "zero syndrome early stop", lat, 3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule